// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Monitor

This block sits beside the command bus of a four-bank synchronous DRAM and watches it at every rising clock edge. It decodes the chip-select, row strobe, column strobe and write-enable lines and the two bank-select bits. From these it keeps an idle/open state and the open row for each bank. Commands that break the bank rules or come too early raise dedicated error pulses. The block drives nothing on the memory bus. It is meant for a controller's verification environment or for an on-chip protocol guard.

Each bank runs a two-state machine. `BK_IDLE` moves to `BK_OPEN` on the transition *open* (an activate aimed at the bank). `BK_OPEN` moves back to `BK_IDLE` on *close*: a precharge aimed at the bank, an all-bank precharge, or a read or write with the auto-precharge bit set. All other cycles are *hold* transitions. A bank-to-bank spacing machine has two states. It enters `SP_GUARD` on any *open* transition and returns to `SP_QUIET` once the cross-bank gap has elapsed. One saturating cycle counter per bank measures the distance since that bank's last *open*. The same counter serves the activate-to-access limit, the same-bank reactivation limit and the maximum open time.

Top module: `sdram_act_monitor`

## Requirements
- R1: Commands decode at a rising edge with chip-select low, using {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 111 no-op. While cs_n is high the cycle has no effect on state or error outputs.
- R2: An activate to an idle bank opens that bank. The bank number is {ba[1],ba[0]}, so 00 is bank 0 and 11 is bank 3. One cycle later bank_active[bank] is 1 and open_row[bank*13 +: 13] holds addr[12:0].
- R3: A read or write to an idle bank pulses err_idle_access for one cycle, with err_bank set to the bank addressed.
- R4: A read or write to an open bank fewer than TRCD cycles after its activate pulses err_early_access. At exactly TRCD cycles the access is legal.
- R5: An activate to a bank that is already open pulses err_double_act. The bank's open row is unchanged.
- R6: A precharge with addr[10]=0 closes only the addressed bank. With addr[10]=1 it closes all banks. A closed bank reports an open row of 0.
- R7: A read or write with addr[10]=1 is performed and then closes the bank (auto precharge).
- R8: An activate that opens a bank fewer than TRC cycles after that bank's previous opening activate pulses err_trc. At exactly TRC cycles it is legal.
- R9: An activate that opens a bank other than the most recently opened one, fewer than TRRD cycles after that opening, pulses err_trrd. At exactly TRRD cycles it is legal.
- R10: A bank still open TRAS_MAX cycles after its activate pulses err_ras_max once, and the bank stays open.
- R11: A synchronous reset (rst high) makes all banks idle, clears all rows and error outputs, and makes the first activate after reset legal.
- R12: err_bank reports the commanded bank when any command error (R3, R4, R5, R8, R9) pulses. Otherwise it reports the lowest-numbered bank raising err_ras_max.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address on activate; bit 10 selects all-bank or auto precharge |
| err_idle_access | output | 1 | Access to an idle bank |
| err_early_access | output | 1 | Access before TRCD |
| err_double_act | output | 1 | Activate to an open bank |
| err_trc | output | 1 | Same-bank activate before TRC |
| err_trrd | output | 1 | Cross-bank activate before TRRD |
| err_ras_max | output | 1 | Bank open for TRAS_MAX cycles |
| err_bank | output | 2 | Bank tied to the current error pulse |
| bank_active | output | 4 | Open flag per bank |
| open_row | output | 52 | Open row per bank, 13 bits each, bank 0 lowest |

## Verification
Every result is due one rising edge after the command that causes it. State, rows and error pulses are all registered at the edge that samples the command. The driver applies each command at a falling edge and queues the outputs it expects after the next rising edge. The monitor pops one item 5 ns after every rising edge and compares it there, so each item lines up with exactly one command cycle. The timing windows are measured as step counts between commands. The tRAS pulse is expected at exactly step TRAS_MAX after its activate, and the following step must be quiet.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic {
        BK_IDLE,
        BK_OPEN
    } bank_st_e;

    typedef enum logic {
        SP_QUIET,
        SP_GUARD
    } space_st_e;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/bank_tracker.sv
module bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int ROW_W    = 13,
    parameter int TRCD     = 3,
    parameter int TRC      = 9,
    parameter int TRAS_MAX = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic             a10,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             opening,
    output logic             v_idle,
    output logic             v_early,
    output logic             v_dbl,
    output logic             v_trc,
    output logic             v_ras
);
    localparam int LIMIT   = ((TRC > TRAS_MAX) ? TRC : TRAS_MAX) + 1;
    localparam int CW      = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(LIMIT);
    localparam logic [CW-1:0] TRCD_C   = CW'(TRCD);
    localparam logic [CW-1:0] TRC_C    = CW'(TRC);
    localparam logic [CW-1:0] TRAS_C   = CW'(TRAS_MAX);

    bank_st_e        st, st_nxt;
    logic [CW-1:0]   cnt;
    logic            acc, act, pre, close_ap, closing;

    always_comb begin
        acc      = sel && (cmd == CMD_RD || cmd == CMD_WR);
        act      = sel && (cmd == CMD_ACT);
        pre      = (cmd == CMD_PRE) && (a10 || sel);
        close_ap = acc && a10;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            BK_IDLE: if (act) st_nxt = BK_OPEN;
            BK_OPEN: if (pre || close_ap) st_nxt = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= BK_IDLE;
        else     st <= st_nxt;
    end

    always_comb begin
        opening = (st == BK_IDLE) && act;
        closing = (st == BK_OPEN) && (pre || close_ap);
        is_open = (st == BK_OPEN);
        v_idle  = acc && (st == BK_IDLE);
        v_early = acc && (st == BK_OPEN) && (cnt < TRCD_C);
        v_dbl   = act && (st == BK_OPEN);
        v_trc   = opening && (cnt < TRC_C);
        v_ras   = (st == BK_OPEN) && (cnt == TRAS_C) && !closing;
    end

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= CNT_SAT;
        else if (opening)        cnt <= CW'(1);
        else if (cnt != CNT_SAT) cnt <= cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)          row_q <= '0;
        else if (opening) row_q <= row_in;
        else if (closing) row_q <= '0;
    end

    p_open_row_r2: assert property (@(posedge clk) disable iff (rst)
        opening |=> (st == BK_OPEN) && (row_q == $past(row_in)));

    p_pre_close_r6: assert property (@(posedge clk) disable iff (rst)
        ((st == BK_OPEN) && pre) |=> (st == BK_IDLE) && (row_q == '0));

    p_ap_close_r7: assert property (@(posedge clk) disable iff (rst)
        ((st == BK_OPEN) && close_ap) |=> (st == BK_IDLE));

endmodule

// File: rtl/act_spacing.sv
module act_spacing
    import sdram_mon_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BA_W  = 2,
    parameter int TRRD  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBANK-1:0] open_vec,
    input  logic [BA_W-1:0]  open_bank,
    output logic             v_trrd
);
    localparam int GW = $clog2(TRRD + 1) + 1;
    localparam logic [GW-1:0] TRRD_C = GW'(TRRD);

    space_st_e       st, st_nxt;
    logic [GW-1:0]   gap;
    logic [BA_W-1:0] last_bank;
    logic            any_open;

    always_comb begin
        any_open = |open_vec;
        st_nxt   = st;
        unique case (st)
            SP_QUIET: if (any_open && TRRD > 1) st_nxt = SP_GUARD;
            SP_GUARD: begin
                if (any_open)                      st_nxt = (TRRD > 1) ? SP_GUARD : SP_QUIET;
                else if (gap + GW'(1) >= TRRD_C)   st_nxt = SP_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SP_QUIET;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= TRRD_C;
            last_bank <= '0;
        end else if (any_open) begin
            gap       <= GW'(1);
            last_bank <= open_bank;
        end else if (st == SP_GUARD) begin
            gap       <= gap + GW'(1);
        end
    end

    always_comb begin
        v_trrd = any_open && (st == SP_GUARD) && (open_bank != last_bank);
    end

    p_single_open_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(open_vec));

endmodule

// File: rtl/sdram_act_monitor.sv
module sdram_act_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int ROW_W    = 13,
    parameter int AP_BIT   = 10,
    parameter int TRCD     = 3,
    parameter int TRC      = 9,
    parameter int TRRD     = 2,
    parameter int TRAS_MAX = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [BA_W-1:0]          ba,
    input  logic [ROW_W-1:0]         addr,
    output logic                     err_idle_access,
    output logic                     err_early_access,
    output logic                     err_double_act,
    output logic                     err_trc,
    output logic                     err_trrd,
    output logic                     err_ras_max,
    output logic [BA_W-1:0]          err_bank,
    output logic [(1<<BA_W)-1:0]     bank_active,
    output logic [(1<<BA_W)*ROW_W-1:0] open_row
);
    localparam int NBANK = 1 << BA_W;

    cmd_e              cmd;
    logic [NBANK-1:0]  v_idle, v_early, v_dbl, v_trc, v_ras, opening;
    logic              v_trrd, cmd_err;
    logic [BA_W-1:0]   ras_bank, bank_d;
    logic [ROW_W-1:0]  row_q [NBANK];

    always_comb cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_tracker #(
            .ROW_W(ROW_W), .TRCD(TRCD), .TRC(TRC), .TRAS_MAX(TRAS_MAX)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .sel    (ba == BA_W'(b)),
            .a10    (addr[AP_BIT]),
            .row_in (addr),
            .is_open(bank_active[b]),
            .row_q  (row_q[b]),
            .opening(opening[b]),
            .v_idle (v_idle[b]),
            .v_early(v_early[b]),
            .v_dbl  (v_dbl[b]),
            .v_trc  (v_trc[b]),
            .v_ras  (v_ras[b])
        );
        assign open_row[b*ROW_W +: ROW_W] = row_q[b];
    end

    act_spacing #(.NBANK(NBANK), .BA_W(BA_W), .TRRD(TRRD)) u_space (
        .clk      (clk),
        .rst      (rst),
        .open_vec (opening),
        .open_bank(ba),
        .v_trrd   (v_trrd)
    );

    always_comb begin
        cmd_err  = (|v_idle) || (|v_early) || (|v_dbl) || (|v_trc) || v_trrd;
        ras_bank = '0;
        for (int b = NBANK - 1; b >= 0; b--) begin
            if (v_ras[b]) ras_bank = BA_W'(b);
        end
        bank_d = cmd_err ? ba : ras_bank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_idle_access  <= 1'b0;
            err_early_access <= 1'b0;
            err_double_act   <= 1'b0;
            err_trc          <= 1'b0;
            err_trrd         <= 1'b0;
            err_ras_max      <= 1'b0;
            err_bank         <= '0;
        end else begin
            err_idle_access  <= |v_idle;
            err_early_access <= |v_early;
            err_double_act   <= |v_dbl;
            err_trc          <= |v_trc;
            err_trrd         <= v_trrd;
            err_ras_max      <= |v_ras;
            err_bank         <= bank_d;
        end
    end

    p_desel_hold_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (bank_active == $past(bank_active)) && !err_idle_access
                 && !err_early_access && !err_double_act && !err_trc && !err_trrd);

    p_idle_access_r3: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD || cmd == CMD_WR) && !bank_active[ba])
            |=> err_idle_access && (err_bank == $past(ba)));

    p_double_act_r5: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_ACT) && bank_active[ba]) |=> err_double_act && $stable(open_row));

endmodule

// File: tb/sdram_act_monitor_test.sv
module sdram_act_monitor_test;

    localparam int TRCD = 3, TRC = 9, TRRD = 2, TRAS = 1024;

    localparam logic [5:0] E_IDLE  = 6'b000001;
    localparam logic [5:0] E_EARLY = 6'b000010;
    localparam logic [5:0] E_DBL   = 6'b000100;
    localparam logic [5:0] E_TRC   = 6'b001000;
    localparam logic [5:0] E_TRRD  = 6'b010000;
    localparam logic [5:0] E_RAS   = 6'b100000;

    typedef enum int { K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_DES } kind_e;

    typedef struct {
        logic [5:0]  err;
        logic [1:0]  bank;
        logic [3:0]  act;
        int          row_bank;
        logic [12:0] row;
        bit          chk_row;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic err_idle_access, err_early_access, err_double_act, err_trc, err_trrd, err_ras_max;
    logic [1:0]  err_bank;
    logic [3:0]  bank_active;
    logic [51:0] open_row;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t q[$];

    always #10 clk = ~clk;

    sdram_act_monitor #(
        .TRCD(TRCD), .TRC(TRC), .TRRD(TRRD), .TRAS_MAX(TRAS)
    ) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr),
        .err_idle_access(err_idle_access), .err_early_access(err_early_access),
        .err_double_act(err_double_act), .err_trc(err_trc), .err_trrd(err_trrd),
        .err_ras_max(err_ras_max), .err_bank(err_bank),
        .bank_active(bank_active), .open_row(open_row)
    );

    task automatic step(input kind_e k, input logic [1:0] b, input logic [12:0] a,
                        input logic [5:0] e, input logic [1:0] eb, input logic [3:0] ea,
                        input bit cr, input int rb, input logic [12:0] rv, input string tag);
        item_t it;
        @(negedge clk);
        cs_n = 1'b0;
        unique case (k)
            K_NOP: {ras_n, cas_n, we_n} = 3'b111;
            K_ACT: {ras_n, cas_n, we_n} = 3'b011;
            K_RD:  {ras_n, cas_n, we_n} = 3'b101;
            K_WR:  {ras_n, cas_n, we_n} = 3'b100;
            K_PRE: {ras_n, cas_n, we_n} = 3'b010;
            K_DES: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
        endcase
        ba = b;
        addr = a;
        it.err = e; it.bank = eb; it.act = ea;
        it.chk_row = cr; it.row_bank = rb; it.row = rv; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic nop(input logic [3:0] ea, input string tag);
        step(K_NOP, 2'd0, 13'd0, 6'd0, 2'd0, ea, 1'b0, 0, 13'd0, tag);
    endtask

    always begin
        @(posedge clk);
        #5;
        if (q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            logic [12:0] grow;
            bit bad;
            it = q.pop_front();
            got = {err_ras_max, err_trrd, err_trc, err_double_act, err_early_access, err_idle_access};
            grow = open_row[it.row_bank*13 +: 13];
            bad = (got != it.err) || (bank_active != it.act)
                  || ((it.err != 0) && (err_bank != it.bank))
                  || (it.chk_row && (grow != it.row));
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: err=%b/%b bank=%0d/%0d active=%b/%b row=%h/%h (actual/expected)",
                         it.tag, got, it.err, err_bank, it.bank, bank_active, it.act,
                         grow, it.row);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if ({err_ras_max, err_trrd, err_trc, err_double_act, err_early_access, err_idle_access} != 0
            || bank_active != 0 || open_row != 0) begin
            errors++;
            $display("FAIL R11 reset: active=%b row=%h actual, expected 0/0", bank_active, open_row);
        end
        // R11 / R2: first activate after reset is legal and opens bank 0
        step(K_ACT, 2'd0, 13'h0123, 0, 0, 4'b0001, 1, 0, 13'h0123, "R2 R11 first activate");
        // R1: deselected cycle with activate pattern does nothing
        step(K_DES, 2'd1, 13'h0777, 0, 0, 4'b0001, 1, 1, 13'h0, "R1 deselect ignored");
        // R4: read two cycles after activate is early
        step(K_RD, 2'd0, 13'h0, E_EARLY, 0, 4'b0001, 0, 0, 0, "R4 early read");
        // R9: three cycles after last opening, bank 1 opens legally
        step(K_ACT, 2'd1, 13'h00AA, 0, 0, 4'b0011, 1, 1, 13'h00AA, "R2 R9 open bank1");
        step(K_RD, 2'd0, 13'h0, 0, 0, 4'b0011, 0, 0, 0, "R4 read bank0 late");
        step(K_WR, 2'd1, 13'h0, E_EARLY, 2'd1, 4'b0011, 0, 0, 0, "R4 early write bank1");
        // R4: exactly TRCD cycles is legal
        step(K_WR, 2'd1, 13'h0, 0, 0, 4'b0011, 0, 0, 0, "R4 boundary write");
        // R5: activate an open bank
        step(K_ACT, 2'd0, 13'h0456, E_DBL, 2'd0, 4'b0011, 1, 0, 13'h0123, "R5 double activate");
        step(K_ACT, 2'd2, 13'h1FFF, 0, 0, 4'b0111, 1, 2, 13'h1FFF, "R2 open bank2");
        // R9: next cycle, other bank
        step(K_ACT, 2'd3, 13'h0005, E_TRRD, 2'd3, 4'b1111, 1, 3, 13'h0005, "R9 trrd violation");
        // R6: single-bank precharge
        step(K_PRE, 2'd2, 13'h0, 0, 0, 4'b1011, 1, 2, 13'h0, "R6 precharge bank2");
        // R8: reopen bank2 three cycles after its activate; R9 boundary (2 after bank3)
        step(K_ACT, 2'd2, 13'h0042, E_TRC, 2'd2, 4'b1111, 1, 2, 13'h0042, "R8 R9 trc violation");
        // R7: read with auto precharge closes bank0
        step(K_RD, 2'd0, 13'h0400, 0, 0, 4'b1110, 1, 0, 13'h0, "R7 read auto precharge");
        // R3: read idle bank
        step(K_RD, 2'd0, 13'h0, E_IDLE, 2'd0, 4'b1110, 0, 0, 0, "R3 idle read");
        step(K_WR, 2'd1, 13'h0400, 0, 0, 4'b1100, 0, 0, 0, "R7 write auto precharge");
        // R6: all-bank precharge
        step(K_PRE, 2'd0, 13'h0400, 0, 0, 4'b0000, 1, 3, 13'h0, "R6 precharge all");
        // R8: bank2 opened 5 cycles ago
        step(K_ACT, 2'd2, 13'h0011, E_TRC, 2'd2, 4'b0100, 1, 2, 13'h0011, "R8 trc second");
        step(K_PRE, 2'd2, 13'h0, 0, 0, 4'b0000, 0, 0, 0, "R6 close bank2");
        for (int i = 0; i < TRC - 2; i++) nop(4'b0000, "R8 gap");
        step(K_ACT, 2'd2, 13'h0ABC, 0, 0, 4'b0100, 1, 2, 13'h0ABC, "R8 trc boundary");
        // R10 + R12: bank2 held; timeout coincides with idle read to bank0
        for (int i = 0; i < TRAS - 1; i++) nop(4'b0100, "R10 hold");
        step(K_RD, 2'd0, 13'h0, E_RAS | E_IDLE, 2'd0, 4'b0100, 0, 0, 0, "R10 R12 ras with command error");
        nop(4'b0100, "R10 single pulse");
        step(K_PRE, 2'd2, 13'h0, 0, 0, 4'b0000, 0, 0, 0, "R6 close after ras");
        step(K_ACT, 2'd1, 13'h0099, 0, 0, 4'b0010, 1, 1, 13'h0099, "R2 open bank1");
        for (int i = 0; i < TRAS - 1; i++) nop(4'b0010, "R10 hold bank1");
        step(K_NOP, 2'd0, 13'h0, E_RAS, 2'd1, 4'b0010, 1, 1, 13'h0099, "R10 R12 ras bank1");
        nop(4'b0010, "R10 stays open");
        step(K_PRE, 2'd1, 13'h0, 0, 0, 4'b0000, 0, 0, 0, "R6 final close");
        @(posedge clk);
        #8;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule